// File: doc/BRIEF.md
# Serial Receiver with Line Status Flags

This block recovers characters from an asynchronous serial line. The line passes first through a synchronizer. The block then watches the line on a clock-enable tick that runs at a fixed multiple of the bit rate, which is sixteen by default. After a start bit has been confirmed, the block gathers five to eight data bits, least significant bit first. It then checks an optional parity bit and a stop bit. The finished character goes into a single holding byte that the host reads.

Next to the holding byte the block keeps five status flags:

- data ready
- overrun
- parity error
- framing error
- break detected

Data ready follows the holding byte and clears when the host strobes a data read. The four error flags stay set until the host strobes a status read.

A loopback select takes the receiver's line input from the local transmitter's serial output in place of the external pin. This lets software test the path without a cable.

Top module: `serial_rx_lsr`

## Requirements
- R1: The character length is set by `wlen_i` (00 = 5, 01 = 6, 10 = 7, 11 = 8 data bits), received least significant bit first. In the stored byte, bit positions at and above the length are zero.
- R2: Storing a character sets `data_ready_o` and shows the byte on `rx_data_o`. A one-cycle `rd_data_i` strobe clears `data_ready_o`, unless a new character is stored in the same cycle.
- R3: If a character is stored while `data_ready_o` is set and no data read is strobed in that cycle, the new character replaces the old one and `overrun_o` is set.
- R4: When `par_en_i` is 1, a parity bit follows the data. `par_mode_i` selects the check: 00 odd (data plus parity has an odd count of ones), 01 even, 10 parity bit must be 0, 11 parity bit must be 1. A mismatch sets `parity_err_o`. When `par_en_i` is 0, no parity bit is expected and `parity_err_o` is never set.
- R5: A stop bit sampled low, in a frame that held at least one high bit, sets `framing_err_o`. The character is still stored.
- R6: A frame in which every sample is low (start, data, parity if enabled, and stop) sets `break_o` instead of `framing_err_o` and stores the character 0x00. No new start is taken until the line has returned high.
- R7: The four error flags stay set across data reads. A one-cycle `rd_lsr_i` strobe clears all four, unless a new event sets one in the same cycle.
- R8: With `loop_en_i` at 1, the receiver takes its line from `loop_txd_i` and ignores `rxd_i`. With `loop_en_i` at 0, it uses `rxd_i`.
- R9: A falling edge is accepted as a start bit only if the line is still low at the middle of the start bit. A shorter low pulse stores nothing.
- R10: After reset, all five flags and `rx_data_o` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Oversampling enable, one pulse per 1/OVERSAMPLE of a bit time |
| rxd_i | input | 1 | External serial line, idle high |
| loop_txd_i | input | 1 | Local transmitter serial output, used in loopback |
| loop_en_i | input | 1 | Selects loopback as the line source |
| wlen_i | input | 2 | Character length code |
| par_en_i | input | 1 | Parity bit present and checked |
| par_mode_i | input | 2 | Parity check type |
| rd_data_i | input | 1 | Host read strobe for the receive byte |
| rd_lsr_i | input | 1 | Host read strobe for the status flags |
| rx_data_o | output | 8 | Receive holding byte |
| data_ready_o | output | 1 | A character is waiting |
| overrun_o | output | 1 | An unread character was overwritten |
| parity_err_o | output | 1 | Parity mismatch seen |
| framing_err_o | output | 1 | Stop bit sampled low |
| break_o | output | 1 | Whole frame held low |

## Verification
The case that is hardest to reach from the ports is telling a break apart from a framing error. Both end with a low stop sample. Only the state of every earlier sample separates them, and after a break the receiver must also wait for the line to recover before it accepts another start. The bench reaches both cases with directed frames. One holds the line low for the full frame length and then releases it. The other keeps a 0x5A data pattern but drives the stop bit low, and then raises the line within a few ticks so that the trailing low edge is rejected as a short start pulse. Overrun is reached by sending two frames back to back with no read strobe in between. Loopback is reached with the external pin held low, which would otherwise look like a break.

// File: rtl/serial_rx_pkg.sv
package serial_rx_pkg;

   typedef enum logic [2:0] {
      RX_IDLE,
      RX_START,
      RX_DATA,
      RX_PAR,
      RX_STOP,
      RX_HOLD
   } rx_state_e;

   localparam logic [1:0] PM_ODD  = 2'b00;
   localparam logic [1:0] PM_EVEN = 2'b01;
   localparam logic [1:0] PM_ZERO = 2'b10;
   localparam logic [1:0] PM_ONE  = 2'b11;

   // Expected parity bit, given the XOR of the received data bits.
   function automatic logic want_parity(input logic [1:0] mode, input logic acc);
      logic r;
      case (mode)
         PM_ODD:  r = ~acc;
         PM_EVEN: r = acc;
         PM_ZERO: r = 1'b0;
         default: r = 1'b1;
      endcase
      return r;
   endfunction

endpackage

// File: rtl/serial_rx_sync.sv
module serial_rx_sync #(
   parameter int   STAGES    = 2,
   parameter logic RESET_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_i,
   output logic q_o
);
   logic [STAGES-1:0] chain;

   generate
      if (STAGES < 2) begin : g_bad
         $error("serial_rx_sync: STAGES must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= {STAGES{RESET_VAL}};
      else        chain <= {chain[STAGES-2:0], d_i};
   end

   assign q_o = chain[STAGES-1];
endmodule

// File: rtl/serial_rx_frame.sv
module serial_rx_frame
   import serial_rx_pkg::*;
#(
   parameter int OVERSAMPLE = 16
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       tick_i,
   input  logic       line_i,
   input  logic [1:0] wlen_i,
   input  logic       par_en_i,
   input  logic [1:0] par_mode_i,
   output logic       done_o,
   output logic [7:0] data_o,
   output logic       perr_o,
   output logic       ferr_o,
   output logic       brk_o
);
   localparam int             CNT_W     = $clog2(OVERSAMPLE);
   localparam logic [CNT_W-1:0] MID_LAST  = CNT_W'(OVERSAMPLE / 2 - 1);
   localparam logic [CNT_W-1:0] FULL_LAST = CNT_W'(OVERSAMPLE - 1);

   rx_state_e        state;
   logic [CNT_W-1:0] cnt;
   logic [2:0]       bit_idx;
   logic [7:0]       shreg;
   logic             par_acc;
   logic             par_bit;
   logic             seen_one;
   logic [2:0]       last_idx;
   logic             at_mid;
   logic             at_full;

   assign last_idx = 3'd4 + {1'b0, wlen_i};
   assign at_mid   = tick_i && (cnt == MID_LAST);
   assign at_full  = tick_i && (cnt == FULL_LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= RX_IDLE;
         cnt      <= '0;
         bit_idx  <= '0;
         shreg    <= '0;
         par_acc  <= 1'b0;
         par_bit  <= 1'b0;
         seen_one <= 1'b0;
         done_o   <= 1'b0;
         data_o   <= '0;
         perr_o   <= 1'b0;
         ferr_o   <= 1'b0;
         brk_o    <= 1'b0;
      end else begin
         done_o <= 1'b0;
         case (state)
            RX_IDLE: begin
               if (tick_i && !line_i) begin
                  state    <= RX_START;
                  cnt      <= '0;
                  seen_one <= 1'b0;
               end
            end
            RX_START: begin
               if (at_mid) begin
                  cnt <= '0;
                  if (line_i) begin
                     state <= RX_IDLE;
                  end else begin
                     state   <= RX_DATA;
                     bit_idx <= '0;
                     shreg   <= '0;
                     par_acc <= 1'b0;
                  end
               end else if (tick_i) begin
                  cnt <= cnt + 1'b1;
               end
            end
            RX_DATA: begin
               if (at_full) begin
                  cnt             <= '0;
                  shreg[bit_idx]  <= line_i;
                  par_acc         <= par_acc ^ line_i;
                  seen_one        <= seen_one | line_i;
                  if (bit_idx == last_idx) begin
                     state <= par_en_i ? RX_PAR : RX_STOP;
                  end else begin
                     bit_idx <= bit_idx + 1'b1;
                  end
               end else if (tick_i) begin
                  cnt <= cnt + 1'b1;
               end
            end
            RX_PAR: begin
               if (at_full) begin
                  cnt      <= '0;
                  par_bit  <= line_i;
                  seen_one <= seen_one | line_i;
                  state    <= RX_STOP;
               end else if (tick_i) begin
                  cnt <= cnt + 1'b1;
               end
            end
            RX_STOP: begin
               if (at_full) begin
                  cnt    <= '0;
                  done_o <= 1'b1;
                  if (!line_i && !seen_one) begin
                     data_o <= '0;
                     brk_o  <= 1'b1;
                     ferr_o <= 1'b0;
                     perr_o <= 1'b0;
                     state  <= RX_HOLD;
                  end else begin
                     data_o <= shreg;
                     brk_o  <= 1'b0;
                     ferr_o <= !line_i;
                     perr_o <= par_en_i && (par_bit != want_parity(par_mode_i, par_acc));
                     state  <= RX_IDLE;
                  end
               end else if (tick_i) begin
                  cnt <= cnt + 1'b1;
               end
            end
            RX_HOLD: begin
               if (line_i) state <= RX_IDLE;
            end
            default: state <= RX_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/serial_rx_status.sv
module serial_rx_status (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       done_i,
   input  logic [7:0] data_i,
   input  logic       perr_i,
   input  logic       ferr_i,
   input  logic       brk_i,
   input  logic       rd_data_i,
   input  logic       rd_lsr_i,
   output logic [7:0] rx_data_o,
   output logic       data_ready_o,
   output logic       overrun_o,
   output logic       parity_err_o,
   output logic       framing_err_o,
   output logic       break_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rx_data_o     <= '0;
         data_ready_o  <= 1'b0;
         overrun_o     <= 1'b0;
         parity_err_o  <= 1'b0;
         framing_err_o <= 1'b0;
         break_o       <= 1'b0;
      end else begin
         if (done_i)         rx_data_o <= data_i;

         if (done_i)         data_ready_o <= 1'b1;
         else if (rd_data_i) data_ready_o <= 1'b0;

         if (done_i && data_ready_o && !rd_data_i) overrun_o <= 1'b1;
         else if (rd_lsr_i)                        overrun_o <= 1'b0;

         if (done_i && perr_i) parity_err_o <= 1'b1;
         else if (rd_lsr_i)    parity_err_o <= 1'b0;

         if (done_i && ferr_i) framing_err_o <= 1'b1;
         else if (rd_lsr_i)    framing_err_o <= 1'b0;

         if (done_i && brk_i)  break_o <= 1'b1;
         else if (rd_lsr_i)    break_o <= 1'b0;
      end
   end
endmodule

// File: rtl/serial_rx_lsr.sv
module serial_rx_lsr #(
   parameter int OVERSAMPLE  = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       tick_i,
   input  logic       rxd_i,
   input  logic       loop_txd_i,
   input  logic       loop_en_i,
   input  logic [1:0] wlen_i,
   input  logic       par_en_i,
   input  logic [1:0] par_mode_i,
   input  logic       rd_data_i,
   input  logic       rd_lsr_i,
   output logic [7:0] rx_data_o,
   output logic       data_ready_o,
   output logic       overrun_o,
   output logic       parity_err_o,
   output logic       framing_err_o,
   output logic       break_o
);
   generate
      if (OVERSAMPLE < 4 || (OVERSAMPLE % 2) != 0) begin : g_bad_os
         $error("serial_rx_lsr: OVERSAMPLE must be even and at least 4");
      end
   endgenerate

   logic       line_raw;
   logic       line_s;
   logic       frm_done;
   logic [7:0] frm_data;
   logic       frm_perr;
   logic       frm_ferr;
   logic       frm_brk;

   assign line_raw = loop_en_i ? loop_txd_i : rxd_i;

   serial_rx_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   (line_raw),
      .q_o   (line_s)
   );

   serial_rx_frame #(.OVERSAMPLE(OVERSAMPLE)) u_frame (
      .clk        (clk),
      .rst_n      (rst_n),
      .tick_i     (tick_i),
      .line_i     (line_s),
      .wlen_i     (wlen_i),
      .par_en_i   (par_en_i),
      .par_mode_i (par_mode_i),
      .done_o     (frm_done),
      .data_o     (frm_data),
      .perr_o     (frm_perr),
      .ferr_o     (frm_ferr),
      .brk_o      (frm_brk)
   );

   serial_rx_status u_status (
      .clk           (clk),
      .rst_n         (rst_n),
      .done_i        (frm_done),
      .data_i        (frm_data),
      .perr_i        (frm_perr),
      .ferr_i        (frm_ferr),
      .brk_i         (frm_brk),
      .rd_data_i     (rd_data_i),
      .rd_lsr_i      (rd_lsr_i),
      .rx_data_o     (rx_data_o),
      .data_ready_o  (data_ready_o),
      .overrun_o     (overrun_o),
      .parity_err_o  (parity_err_o),
      .framing_err_o (framing_err_o),
      .break_o       (break_o)
   );
endmodule

// File: rtl/serial_rx_lsr_chk.sv
module serial_rx_lsr_chk (
   input logic       clk,
   input logic       rst_n,
   input logic [1:0] wlen_i,
   input logic       par_en_i,
   input logic       rd_data_i,
   input logic       rd_lsr_i,
   input logic [7:0] rx_data_o,
   input logic       data_ready_o,
   input logic       overrun_o,
   input logic       parity_err_o,
   input logic       framing_err_o,
   input logic       break_o,
   input logic       frm_done,
   input logic [7:0] frm_data,
   input logic       frm_perr,
   input logic       frm_ferr,
   input logic       frm_brk
);
   logic [7:0] len_mask;
   always_comb begin
      case (wlen_i)
         2'b00:   len_mask = 8'h1F;
         2'b01:   len_mask = 8'h3F;
         2'b10:   len_mask = 8'h7F;
         default: len_mask = 8'hFF;
      endcase
   end

   p_upper_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
      frm_done |-> ((frm_data & ~len_mask) == 8'h00));

   p_store_r2: assert property (@(posedge clk) disable iff (!rst_n)
      frm_done |=> (data_ready_o && rx_data_o == $past(frm_data)));

   p_read_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_data_i && !frm_done) |=> !data_ready_o);

   p_overrun_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (frm_done && data_ready_o && !rd_data_i) |=> overrun_o);

   p_no_parity_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (frm_done && !par_en_i) |-> !frm_perr);

   p_break_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (frm_done && frm_brk) |-> (frm_data == 8'h00 && !frm_ferr));

   p_lsr_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_lsr_i && !frm_done) |=> !(overrun_o || parity_err_o || framing_err_o || break_o));

   p_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (overrun_o && !rd_lsr_i) |=> overrun_o);

   p_done_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
      frm_done |=> !frm_done);
endmodule

bind serial_rx_lsr serial_rx_lsr_chk u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .wlen_i        (wlen_i),
   .par_en_i      (par_en_i),
   .rd_data_i     (rd_data_i),
   .rd_lsr_i      (rd_lsr_i),
   .rx_data_o     (rx_data_o),
   .data_ready_o  (data_ready_o),
   .overrun_o     (overrun_o),
   .parity_err_o  (parity_err_o),
   .framing_err_o (framing_err_o),
   .break_o       (break_o),
   .frm_done      (frm_done),
   .frm_data      (frm_data),
   .frm_perr      (frm_perr),
   .frm_ferr      (frm_ferr),
   .frm_brk       (frm_brk)
);

// File: tb/serial_rx_lsr_tb.sv
module serial_rx_lsr_tb;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick = 1'b0;
   logic [1:0] tdiv = 2'd0;
   logic       ser = 1'b1;
   logic       noise = 1'b1;
   logic       use_loop = 1'b0;
   logic [1:0] wlen = 2'b11;
   logic       par_en = 1'b0;
   logic [1:0] par_mode = 2'b00;
   logic       rd_data = 1'b0;
   logic       rd_lsr = 1'b0;
   logic       rxd, ltx;
   logic [7:0] rx_data;
   logic       dr, ovr, perr, ferr, brk;

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 1'b0;

   always #4 clk = ~clk;

   always @(negedge clk) begin
      tdiv <= tdiv + 2'd1;
      tick <= (tdiv == 2'd3);
   end

   assign rxd = use_loop ? noise : ser;
   assign ltx = use_loop ? ser : 1'b1;

   serial_rx_lsr u_dut (
      .clk(clk), .rst_n(rst_n), .tick_i(tick), .rxd_i(rxd), .loop_txd_i(ltx),
      .loop_en_i(use_loop), .wlen_i(wlen), .par_en_i(par_en), .par_mode_i(par_mode),
      .rd_data_i(rd_data), .rd_lsr_i(rd_lsr), .rx_data_o(rx_data), .data_ready_o(dr),
      .overrun_o(ovr), .parity_err_o(perr), .framing_err_o(ferr), .break_o(brk)
   );

   task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   function automatic logic [7:0] len_mask(input logic [1:0] wl);
      return 8'hFF >> (3 - wl);
   endfunction

   function automatic logic exp_par(input logic [7:0] d, input logic [1:0] wl, input logic [1:0] pm);
      logic x = ^(d & len_mask(wl));
      case (pm)
         2'b00:   return ~x;
         2'b01:   return x;
         2'b10:   return 1'b0;
         default: return 1'b1;
      endcase
   endfunction

   task automatic wait_ticks(input int n);
      repeat (n) begin
         @(posedge clk);
         while (!tick) @(posedge clk);
      end
      #1;
   endtask

   task automatic send_frame(input logic [7:0] d, input logic flip, input logic stop_bit);
      ser = 1'b0; wait_ticks(16);
      for (int i = 0; i <= 4 + int'(wlen); i++) begin
         ser = d[i]; wait_ticks(16);
      end
      if (par_en) begin
         ser = exp_par(d, wlen, par_mode) ^ flip; wait_ticks(16);
      end
      ser = stop_bit; wait_ticks(16);
      ser = 1'b1; wait_ticks(16);
      @(negedge clk);
   endtask

   task automatic pulse_rd_data();
      @(posedge clk); #1 rd_data = 1'b1;
      @(posedge clk); #1 rd_data = 1'b0;
      @(negedge clk);
   endtask

   task automatic pulse_rd_lsr();
      @(posedge clk); #1 rd_lsr = 1'b1;
      @(posedge clk); #1 rd_lsr = 1'b0;
      @(negedge clk);
   endtask

   task automatic check_flags(input string req, input logic e_dr, input logic e_ovr,
                              input logic e_perr, input logic e_ferr, input logic e_brk);
      check(req, "data_ready", {31'd0, dr}, {31'd0, e_dr});
      check(req, "overrun", {31'd0, ovr}, {31'd0, e_ovr});
      check(req, "parity_err", {31'd0, perr}, {31'd0, e_perr});
      check(req, "framing_err", {31'd0, ferr}, {31'd0, e_ferr});
      check(req, "break", {31'd0, brk}, {31'd0, e_brk});
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_tests++;
         n_fail++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      logic [7:0] d;
      logic [7:0] d2;
      void'($urandom(32'd20240611));
      repeat (5) @(posedge clk);
      #1 rst_n = 1'b1;
      @(negedge clk);
      // R10: reset state
      check("R10", "rx_data", {24'd0, rx_data}, 32'd0);
      check_flags("R10", 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
      wait_ticks(20);

      // R1, R2, R4: random frames with every length and parity mode
      for (int k = 0; k < 24; k++) begin
         wlen     = 2'($urandom_range(0, 3));
         par_en   = 1'($urandom_range(0, 1));
         par_mode = 2'($urandom_range(0, 3));
         d        = 8'($urandom_range(0, 255));
         @(negedge clk);
         send_frame(d, 1'b0, 1'b1);
         check("R1", "rx_data", {24'd0, rx_data}, {24'd0, d & len_mask(wlen)});
         check_flags("R2", 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
         pulse_rd_data();
         check("R2", "data_ready after read", {31'd0, dr}, 32'd0);
      end

      // R4: parity mismatch in each mode, then R7 clear on status read
      wlen = 2'b10; par_en = 1'b1;
      for (int m = 0; m < 4; m++) begin
         par_mode = 2'(m);
         @(negedge clk);
         send_frame(8'h35, 1'b1, 1'b1);
         check("R4", "rx_data", {24'd0, rx_data}, 32'h35);
         check("R4", "parity_err on mismatch", {31'd0, perr}, 32'd1);
         pulse_rd_data();
         check("R7", "parity_err kept over data read", {31'd0, perr}, 32'd1);
         pulse_rd_lsr();
         check("R7", "parity_err after status read", {31'd0, perr}, 32'd0);
      end

      // R5: framing error with data present
      wlen = 2'b11; par_en = 1'b0;
      @(negedge clk);
      send_frame(8'h5A, 1'b0, 1'b0);
      check("R5", "rx_data", {24'd0, rx_data}, 32'h5A);
      check_flags("R5", 1'b1, 1'b0, 1'b0, 1'b1, 1'b0);
      pulse_rd_data();
      pulse_rd_lsr();
      check_flags("R7", 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);

      // R6: break (line low for a whole frame, then high)
      par_en = 1'b1; par_mode = 2'b01;
      @(negedge clk);
      ser = 1'b0; wait_ticks(16 * 11 + 8);
      check("R6", "no start accepted while held low", {31'd0, brk}, 32'd1);
      wait_ticks(40);
      ser = 1'b1; wait_ticks(24);
      @(negedge clk);
      check("R6", "rx_data zero on break", {24'd0, rx_data}, 32'd0);
      check_flags("R6", 1'b1, 1'b0, 1'b0, 1'b0, 1'b1);
      pulse_rd_data();
      pulse_rd_lsr();
      check("R7", "break after status read", {31'd0, brk}, 32'd0);
      par_en = 1'b0;

      // R3: overrun by two frames without a read
      d  = 8'($urandom_range(0, 255));
      d2 = 8'($urandom_range(0, 255));
      @(negedge clk);
      send_frame(d, 1'b0, 1'b1);
      check("R3", "first frame overrun clear", {31'd0, ovr}, 32'd0);
      send_frame(d2, 1'b0, 1'b1);
      check("R3", "rx_data replaced", {24'd0, rx_data}, {24'd0, d2});
      check_flags("R3", 1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
      pulse_rd_data();
      check("R7", "overrun kept over data read", {31'd0, ovr}, 32'd1);
      pulse_rd_lsr();
      check("R7", "overrun after status read", {31'd0, ovr}, 32'd0);

      // R9: short low pulse rejected
      ser = 1'b0; wait_ticks(3);
      ser = 1'b1; wait_ticks(16 * 12);
      @(negedge clk);
      check_flags("R9", 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);

      // R8: loopback with the external pin held low
      use_loop = 1'b1; noise = 1'b0; wlen = 2'b11; par_en = 1'b1; par_mode = 2'b00;
      wait_ticks(4);
      @(negedge clk);
      send_frame(8'hC3, 1'b0, 1'b1);
      check("R8", "loopback rx_data", {24'd0, rx_data}, 32'hC3);
      check_flags("R8", 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
      pulse_rd_data();
      noise = 1'b1; use_loop = 1'b0;

      // R8: loopback off, pin used again
      wait_ticks(4);
      @(negedge clk);
      send_frame(8'h81, 1'b0, 1'b1);
      check("R8", "pin rx_data", {24'd0, rx_data}, 32'h81);
      check("R8", "pin data_ready", {31'd0, dr}, 32'd1);

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule